// File: doc/BRIEF.md
# Inter-Core Doorbell Interrupt Controller

This block lets any of three processor cores signal any other core through a small memory-mapped register file on a shared configuration bus. Each destination core owns one "ring" register and one "acknowledge" register. A write to a ring register can raise a one-cycle interrupt event at that core. In the same write it can raise sticky message flags. The destination core later retires those flags through its own acknowledge register.

All senders produce the same single interrupt event at a destination, and the hardware records no sender identity. Software puts any such identity in the 28 flag bits. The interrupt bit and the flag bits are independent fields of one write, so a core can post flags quietly or ring without posting flags. Flags can only be cleared through the acknowledge path. That path accepts a write only from the core that owns it, so a sender can never withdraw a flag it has raised.

Register word layout: bit 0 is the ring bit, bits 3:1 are reserved, and bits 31:4 are the flags. Ring register n sits at byte offset 4·n. Acknowledge register n sits at 0x40 + 4·n.

Top module: `doorbell_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all flags of all cores and drives no interrupt pulse while it is held or in the cycle after it is released.
- R2: A write to the ring register of core n (offset 4·n) with bit 0 set makes `irq_pulse[n]` high for exactly one cycle, in the cycle after the write. Other cores' pulses stay low.
- R3: A ring write with bit 0 clear raises no interrupt pulse.
- R4: In a ring write to core n, each 1 in bits 31:4 sets the matching flag of core n, and each 0 leaves that flag unchanged.
- R5: No ring write ever clears a flag.
- R6: An acknowledge write to core n (offset 0x40 + 4·n) issued with `src_id` equal to n clears the flags of core n where bits 31:4 are 1, and leaves the others unchanged.
- R7: An acknowledge write to core n issued with any other `src_id` has no effect on any flag.
- R8: A read of either the ring or the acknowledge offset of core n returns core n's flags in bits 31:4, with bits 3:0 read as zero. In particular, the ring bit is never stored.
- R9: A read of any other offset, including a misaligned one, returns zero, and a write to it changes no flag and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| src_id | input | 2 | Number of the core issuing the access |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_pulse | output | 3 | One interrupt event line per destination core |

## Verification
On every cycle, the assertions check the following:
- No flag rises without a ring write to its core.
- No flag falls without an acknowledge write from the owning core.
- Every interrupt pulse traces back to a ring write with bit 0 set one cycle earlier.
- Reset leaves nothing pending.

Only the bench's scenarios can show the following:
- The exact flag values after mixed set and clear masks.
- That acknowledge writes from the wrong core and writes to unmapped or misaligned offsets are ignored.
- That both register views of a core read back identically.

// File: rtl/doorbell_ctrl.sv
module doorbell_ctrl #(
  parameter int              NCORES   = 3,
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 32,
  parameter int              ID_W     = 2,
  parameter logic [ADDR_W-1:0] ACK_BASE = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ID_W-1:0]   src_id,
  output logic [DATA_W-1:0] rdata,
  output logic [NCORES-1:0] irq_pulse
);

  localparam int FLAG_LSB = 4;
  localparam int FLAG_W   = DATA_W - FLAG_LSB;

  logic [FLAG_W-1:0] flags_q [NCORES];
  logic [NCORES-1:0] ring_sel, ack_sel, ring_wr, ack_wr, irq_q;
  logic [FLAG_W-1:0] wflags;
  logic              unused_rsvd;

  assign wflags      = wdata[DATA_W-1:FLAG_LSB];
  assign unused_rsvd = ^wdata[FLAG_LSB-1:1];
  assign irq_pulse   = irq_q;

  for (genvar n = 0; n < NCORES; n++) begin : g_core
    logic [FLAG_W-1:0] set_m, clr_m;

    assign ring_sel[n] = (addr == ADDR_W'(4 * n));
    assign ack_sel[n]  = (addr == ACK_BASE + ADDR_W'(4 * n));
    assign ring_wr[n]  = wr_en && ring_sel[n];
    assign ack_wr[n]   = wr_en && ack_sel[n] && (src_id == ID_W'(n));
    assign set_m       = ring_wr[n] ? wflags : '0;
    assign clr_m       = ack_wr[n]  ? wflags : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        flags_q[n] <= '0;
        irq_q[n]   <= 1'b0;
      end else begin
        flags_q[n] <= (flags_q[n] & ~clr_m) | set_m;
        irq_q[n]   <= ring_wr[n] && wdata[0];
      end
    end

    AST_NO_SET_WITHOUT_RING: assert property (@(posedge clk) disable iff (rst)
      !ring_wr[n] |=> ((flags_q[n] & ~$past(flags_q[n])) == '0)); // R4
    AST_NO_CLEAR_WITHOUT_ACK: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && ack_sel[n] && src_id == ID_W'(n)) |=> ((flags_q[n] & $past(flags_q[n])) == $past(flags_q[n]))); // R7
    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && ring_sel[n] && wdata[0]) |=> !irq_pulse[n]); // R2
    AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (flags_q[n] == '0 && !irq_pulse[n])); // R1
  end

  always_comb begin
    rdata = '0;
    for (int n = 0; n < NCORES; n++)
      if (ring_sel[n] || ack_sel[n]) rdata = {flags_q[n], {FLAG_LSB{1'b0}}};
  end

endmodule

// File: tb/test_doorbell_ctrl.sv
module test_doorbell_ctrl;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [1:0]  src_id = '0;
  logic [31:0] rdata;
  logic [2:0]  irq_pulse;

  int compared = 0, mismatched = 0;
  logic [27:0] model [3];

  doorbell_ctrl i_doorbell_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .src_id(src_id), .rdata(rdata), .irq_pulse(irq_pulse));

  always #5 clk = ~clk;

  function automatic logic [7:0] ring_a(int n); return 8'(4 * n); endfunction
  function automatic logic [7:0] ack_a(int n);  return 8'h40 + 8'(4 * n); endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic readback(string req);
    for (int n = 0; n < 3; n++) begin
      addr = ring_a(n); #1;
      chk(rdata == {model[n], 4'b0}, {req, " R8 ring view"}, rdata, {model[n], 4'b0});
      addr = ack_a(n); #1;
      chk(rdata == {model[n], 4'b0}, {req, " R8 ack view"}, rdata, {model[n], 4'b0});
    end
    addr = 8'h4C; #1;
    chk(rdata == 0, {req, " R9 unmapped read"}, rdata, 0);
  endtask

  task automatic do_wr(logic [7:0] a, logic [31:0] d, logic [1:0] s, string req);
    logic [2:0] exp_irq = '0;
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d; src_id = s;
    for (int n = 0; n < 3; n++) begin
      if (a == ring_a(n)) begin
        exp_irq[n] = d[0];
        model[n] |= d[31:4];
      end
      if (a == ack_a(n) && s == 2'(n)) model[n] &= ~d[31:4];
    end
    @(negedge clk);
    wr_en = 0;
    chk(irq_pulse == exp_irq, {req, " R2/R3 pulse"}, 32'(irq_pulse), 32'(exp_irq));
    readback(req);
    @(negedge clk);
    chk(irq_pulse == 0, {req, " R2 single cycle"}, 32'(irq_pulse), 0);
  endtask

  initial begin
    #2_000_000;
    mismatched++; compared++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int n = 0; n < 3; n++) model[n] = '0;
    repeat (3) @(negedge clk);
    chk(irq_pulse == 0, "R1 irq in reset", 32'(irq_pulse), 0);
    rst = 0;
    @(negedge clk);
    chk(irq_pulse == 0, "R1 irq after reset", 32'(irq_pulse), 0);
    readback("R1 reset flags");

    do_wr(ring_a(1), 32'h0000_0001, 2'd0, "R2 ring only");
    do_wr(ring_a(2), 32'hA5A5_A5A0, 2'd0, "R3 flags quiet");
    do_wr(ring_a(2), 32'h0000_000F, 2'd1, "R4 reserved bits");
    do_wr(ring_a(2), 32'h0000_0000, 2'd1, "R5 zero ring");
    do_wr(ring_a(0), 32'hFFFF_FFF1, 2'd2, "R4 all flags");
    do_wr(ack_a(0),  32'hFFFF_FFF0, 2'd1, "R7 wrong owner");
    do_wr(ack_a(0),  32'hFFFF_FFF0, 2'd3, "R7 bad id");
    do_wr(ack_a(0),  32'h0F0F_0F00, 2'd0, "R6 partial ack");
    do_wr(ack_a(2),  32'h0000_0000, 2'd2, "R6 zero ack");
    do_wr(8'h4C,     32'hFFFF_FFFF, 2'd0, "R9 unmapped");
    do_wr(8'h01,     32'hFFFF_FFFF, 2'd0, "R9 misaligned");
    do_wr(8'h0C,     32'hFFFF_FFFF, 2'd0, "R9 past ring");

    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 9);
      int n   = $urandom_range(0, 2);
      logic [31:0] d = $urandom;
      logic [1:0]  s = 2'($urandom_range(0, 3));
      logic [7:0]  a;
      if (sel < 4)      a = ring_a(n);
      else if (sel < 8) a = ack_a(n);
      else              a = 8'($urandom_range(0, 255));
      if (sel == 6) s = 2'(n);
      do_wr(a, d, s, "R4/R6 random");
    end

    do_wr(ring_a(1), 32'h1234_5671, 2'd0, "R1 preload");
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    for (int n = 0; n < 3; n++) model[n] = '0;
    readback("R1 mid-run reset");
    chk(irq_pulse == 0, "R1 irq after mid-run reset", 32'(irq_pulse), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule